// File: doc/BRIEF.md
# Receive Frame Status Qualifier

This block sits beside a receive buffer and watches every Ethernet frame as its bytes are written in. It counts the bytes, tracks whether a collision hit inside the collision window, whether the frame ended before that window closed, and whether the upstream checker flagged a bad CRC. It also notes when the frame grew past the maximum legal length. The frame is never cut short when that happens.

When the last byte arrives, the block latches a status word and a 12-bit byte count. It also decides whether the buffered frame is kept for the host or discarded. A frame with no fault is always kept. A faulty frame is kept only when the host has set the pass-bad control input, and it then arrives with its status bits attached. An 8-bit host reads the count low byte first. That read captures the high byte, so the two halves always belong to the same frame.

Top module: `rx_frame_qualifier`

## Requirements
- R1: The reported byte count in `rpt_bcnt[11:0]` equals the number of accepted bytes from the start byte to the end byte inclusive, saturating at 4095; `rpt_bcnt[15:12]` always reads 0.
- R2: Status bit 2 (too long) is 1 exactly when the count exceeds MAX_LEN (2000): a 2000-byte frame leaves it 0, a 2001-byte frame sets it. The count still reports every byte.
- R3: Status bit 1 (runt) is 1 when the frame ends with fewer than RUNT_LEN (64) bytes, or when `rx_coll` is seen while fewer than 64 bytes of the frame had been accepted before that cycle. A later collision leaves it 0.
- R4: Status bit 0 (CRC error) is 1 when `rx_crc_err` is asserted in any cycle from the start byte through the end byte.
- R5: With all status bits 0, `rpt_keep`=1 whatever `pass_bad` is. With any status bit set, `rpt_keep` equals `pass_bad` sampled on the end byte. After a frame, `rpt_drop` is the inverse of `rpt_keep`, and the two are never 1 together.
- R6: The report (status, count, keep/drop) updates on the clock edge that samples the end byte. `rpt_done` is 1 for that single cycle only. The report holds until a start byte without an end is accepted, and that edge clears status, count, keep and drop to 0.
- R7: A pulse on `host_rd_lo` makes `rpt_bcnt_hi` capture `rpt_bcnt[15:8]` on that edge. Without a pulse, `rpt_bcnt_hi` holds even when a new report arrives.
- R8: After reset every output is 0.
- R9: Bytes with `rx_valid`=1 that arrive outside a frame (no start byte accepted yet) are ignored: they change neither the report nor the next frame's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is written this cycle |
| rx_sof | input | 1 | This byte is the first of a frame (with rx_valid) |
| rx_eof | input | 1 | This byte is the last of a frame (with rx_valid) |
| rx_coll | input | 1 | Collision strobe from the MAC |
| rx_crc_err | input | 1 | Bad-CRC strobe from the upstream checker |
| pass_bad | input | 1 | Keep faulty frames for the host |
| host_rd_lo | input | 1 | Host reads the low count byte |
| rpt_done | output | 1 | One-cycle pulse: report updated |
| rpt_status | output | 16 | Bit2 too long, bit1 runt, bit0 CRC error, others 0 |
| rpt_bcnt | output | 16 | Byte count in bits 11:0, upper bits 0 |
| rpt_keep | output | 1 | Frame kept for the host |
| rpt_drop | output | 1 | Frame discarded |
| rpt_bcnt_hi | output | 8 | High count byte captured on the low-byte read |

## Verification
The bound checker watches a set of rules on every cycle:
- the upper count bits stay zero;
- keep and drop are never both set;
- the too-long bit agrees with the reported count on each report;
- a short count always carries the runt bit;
- a clean frame is always kept;
- a lone start byte clears the report;
- the high read byte either holds or copies the count.

Some behaviour only the directed scenarios can show. This includes the exact count boundaries at 63/64 and 2000/2001, and saturation at 4095. It also includes where a collision falls relative to the window, the pass-bad decision for each fault class, and whether stray bytes outside a frame are ignored.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int STAT_W    = 16;
    localparam int FLAG_CRC  = 0;
    localparam int FLAG_RUNT = 1;
    localparam int FLAG_LONG = 2;
endpackage

// File: rtl/rxq_len_counter.sv
module rxq_len_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             sof_hit,
    output logic             eof_hit,
    output logic             in_frame,
    output logic [CNT_W-1:0] cnt_prev,
    output logic [CNT_W-1:0] len_now
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } len_state_t;

    len_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        sof_hit = rx_valid && rx_sof;
        accept  = sof_hit || (rx_valid && st_q.busy);
        eof_hit = accept && rx_eof;
        if (sof_hit)
            len_now = CNT_ONE;
        else if (st_q.cnt == CNT_MAX)
            len_now = CNT_MAX;
        else
            len_now = st_q.cnt + CNT_ONE;
        st_d = st_q;
        if (accept) begin
            st_d.cnt  = len_now;
            st_d.busy = !rx_eof;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_frame = st_q.busy;
    assign cnt_prev = st_q.cnt;
endmodule

// File: rtl/rxq_flag_track.sv
module rxq_flag_track #(
    parameter int CNT_W    = 12,
    parameter int RUNT_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_hit,
    input  logic             in_frame,
    input  logic [CNT_W-1:0] cnt_prev,
    input  logic             rx_coll,
    input  logic             rx_crc_err,
    output logic             coll_now,
    output logic             crc_now
);
    localparam logic [CNT_W-1:0] WIN = CNT_W'(RUNT_LEN);

    typedef struct packed {
        logic coll;
        logic crc;
    } flag_state_t;

    flag_state_t fl_d, fl_q;
    logic        active;
    logic        in_window;

    always_comb begin
        active    = sof_hit || in_frame;
        in_window = sof_hit || (cnt_prev < WIN);
        coll_now  = (sof_hit ? 1'b0 : fl_q.coll) || (active && rx_coll && in_window);
        crc_now   = (sof_hit ? 1'b0 : fl_q.crc)  || (active && rx_crc_err);
        fl_d      = fl_q;
        if (active) begin
            fl_d.coll = coll_now;
            fl_d.crc  = crc_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end
endmodule

// File: rtl/rxq_host_port.sv
module rxq_host_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_rd_lo,
    input  logic [7:0] bcnt_upper,
    output logic [7:0] bcnt_hi
);
    logic [7:0] hi_d, hi_q;

    always_comb begin
        hi_d = hi_q;
        if (host_rd_lo) hi_d = bcnt_upper;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
    end

    assign bcnt_hi = hi_q;
endmodule

// File: rtl/rx_frame_qualifier.sv
module rx_frame_qualifier #(
    parameter int CNT_W    = 12,
    parameter int MAX_LEN  = 2000,
    parameter int RUNT_LEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_coll,
    input  logic        rx_crc_err,
    input  logic        pass_bad,
    input  logic        host_rd_lo,
    output logic        rpt_done,
    output logic [15:0] rpt_status,
    output logic [15:0] rpt_bcnt,
    output logic        rpt_keep,
    output logic        rpt_drop,
    output logic [7:0]  rpt_bcnt_hi
);
    import rxq_pkg::*;

    localparam logic [CNT_W-1:0] LONG_LIM = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] WIN      = CNT_W'(RUNT_LEN);
    localparam int               PAD_W    = 16 - CNT_W;

    typedef struct packed {
        logic             done;
        logic [2:0]       flags;
        logic [CNT_W-1:0] len;
        logic             keep;
        logic             drop;
    } report_t;

    logic             sof_hit, eof_hit, in_frame;
    logic [CNT_W-1:0] cnt_prev, len_now;
    logic             coll_now, crc_now;
    logic [2:0]       flags_now;
    report_t          rp_d, rp_q;

    rxq_len_counter #(.CNT_W(CNT_W)) u_len (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .sof_hit(sof_hit), .eof_hit(eof_hit),
        .in_frame(in_frame), .cnt_prev(cnt_prev), .len_now(len_now)
    );

    rxq_flag_track #(.CNT_W(CNT_W), .RUNT_LEN(RUNT_LEN)) u_flags (
        .clk(clk), .rst_n(rst_n), .sof_hit(sof_hit), .in_frame(in_frame),
        .cnt_prev(cnt_prev), .rx_coll(rx_coll), .rx_crc_err(rx_crc_err),
        .coll_now(coll_now), .crc_now(crc_now)
    );

    always_comb begin
        flags_now            = '0;
        flags_now[FLAG_LONG] = len_now > LONG_LIM;
        flags_now[FLAG_RUNT] = coll_now || (len_now < WIN);
        flags_now[FLAG_CRC]  = crc_now;

        rp_d      = rp_q;
        rp_d.done = 1'b0;
        if (eof_hit) begin
            rp_d.done  = 1'b1;
            rp_d.flags = flags_now;
            rp_d.len   = len_now;
            rp_d.keep  = (flags_now == 3'b000) || pass_bad;
            rp_d.drop  = !rp_d.keep;
        end else if (sof_hit) begin
            rp_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign rpt_done   = rp_q.done;
    assign rpt_status = {{(STAT_W-3){1'b0}}, rp_q.flags};
    assign rpt_bcnt   = {{PAD_W{1'b0}}, rp_q.len};
    assign rpt_keep   = rp_q.keep;
    assign rpt_drop   = rp_q.drop;

    rxq_host_port u_host (
        .clk(clk), .rst_n(rst_n), .host_rd_lo(host_rd_lo),
        .bcnt_upper(rpt_bcnt[15:8]), .bcnt_hi(rpt_bcnt_hi)
    );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int MAX_LEN  = 2000,
    parameter int RUNT_LEN = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        rx_sof,
    input logic        rx_eof,
    input logic        host_rd_lo,
    input logic        rpt_done,
    input logic [15:0] rpt_status,
    input logic [15:0] rpt_bcnt,
    input logic        rpt_keep,
    input logic        rpt_drop,
    input logic [7:0]  rpt_bcnt_hi
);
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_bcnt[15:12] == 4'd0); // R1
    AST_LONG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_done |-> (rpt_status[2] == (32'(rpt_bcnt) > MAX_LEN))); // R2
    AST_SHORT_IS_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_done && (32'(rpt_bcnt) < RUNT_LEN)) |-> rpt_status[1]); // R3
    AST_KEEP_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rpt_keep && rpt_drop)); // R5
    AST_GOOD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_done && rpt_status[2:0] == 3'b000) |-> rpt_keep); // R5
    AST_CLEAR_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && !rx_eof) |=>
        (rpt_status == 16'd0 && rpt_bcnt == 16'd0 && !rpt_keep && !rpt_drop)); // R6
    AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_lo |=> rpt_bcnt_hi == $past(rpt_bcnt[15:8])); // R7
    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_lo |=> $stable(rpt_bcnt_hi)); // R7
endmodule

bind rx_frame_qualifier rxq_checker #(.MAX_LEN(MAX_LEN), .RUNT_LEN(RUNT_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .host_rd_lo(host_rd_lo), .rpt_done(rpt_done),
    .rpt_status(rpt_status), .rpt_bcnt(rpt_bcnt), .rpt_keep(rpt_keep),
    .rpt_drop(rpt_drop), .rpt_bcnt_hi(rpt_bcnt_hi)
);

// File: tb/tb_rx_frame_qualifier.sv
module tb_rx_frame_qualifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic        rx_coll = 1'b0, rx_crc_err = 1'b0, pass_bad = 1'b0, host_rd_lo = 1'b0;
    logic        rpt_done, rpt_keep, rpt_drop;
    logic [15:0] rpt_status, rpt_bcnt;
    logic [7:0]  rpt_bcnt_hi;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    always #5 clk = ~clk;

    rx_frame_qualifier dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_coll(rx_coll), .rx_crc_err(rx_crc_err),
        .pass_bad(pass_bad), .host_rd_lo(host_rd_lo), .rpt_done(rpt_done),
        .rpt_status(rpt_status), .rpt_bcnt(rpt_bcnt), .rpt_keep(rpt_keep),
        .rpt_drop(rpt_drop), .rpt_bcnt_hi(rpt_bcnt_hi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic idle();
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_coll = 0; rx_crc_err = 0;
    endtask

    task automatic drive_bytes(input int len, input int coll_at, input int crc_at, input bit with_sof);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid   = 1;
            rx_sof     = with_sof && (i == 0);
            rx_eof     = (i == len - 1);
            rx_coll    = (i == coll_at);
            rx_crc_err = (i == crc_at);
        end
        @(negedge clk);
        idle();
    endtask

    // full frame, then check the report on the negedge after the end byte's edge
    task automatic send_frame(input string name, input int len, input int coll_at,
                              input int crc_at, input bit pass);
        int  exp_len;
        bit  e_long, e_runt, e_crc, e_keep;
        pass_bad = pass;
        drive_bytes(len, coll_at, crc_at, 1'b1);
        exp_len = (len > 4095) ? 4095 : len;
        e_long  = len > 2000;
        e_runt  = (len < 64) || (coll_at >= 0 && coll_at < 64);
        e_crc   = crc_at >= 0;
        e_keep  = !(e_long || e_runt || e_crc) || pass;
        chk({name, " R1 count"}, int'(rpt_bcnt), exp_len);
        chk({name, " R2 too long"}, int'(rpt_status[2]), int'(e_long));
        chk({name, " R3 runt"}, int'(rpt_status[1]), int'(e_runt));
        chk({name, " R4 crc"}, int'(rpt_status[0]), int'(e_crc));
        chk({name, " R5 keep"}, int'(rpt_keep), int'(e_keep));
        chk({name, " R5 drop"}, int'(rpt_drop), int'(!e_keep));
        chk({name, " R6 done pulse"}, int'(rpt_done), 1);
        @(negedge clk);
        chk({name, " R6 done one cycle"}, int'(rpt_done), 0);
        chk({name, " R6 report held"}, int'(rpt_bcnt), exp_len);
    endtask

    task automatic t_reset();
        chk("R8 reset status", int'(rpt_status), 0);
        chk("R8 reset count", int'(rpt_bcnt), 0);
        chk("R8 reset keep/drop", int'({rpt_keep, rpt_drop, rpt_done}), 0);
        chk("R8 reset hi", int'(rpt_bcnt_hi), 0);
    endtask

    task automatic t_boundaries();
        send_frame("good64",  64,   -1, -1, 0);
        send_frame("short63", 63,   -1, -1, 0);
        send_frame("short63p",63,   -1, -1, 1);
        send_frame("one",     1,    -1, -1, 0);
        send_frame("len2000", 2000, -1, -1, 0);
        send_frame("len2001", 2001, -1, -1, 0);
        send_frame("len2001p",2001, -1, -1, 1);
        send_frame("sat",     5000, -1, -1, 0);
    endtask

    task automatic t_faults();
        send_frame("coll10",  100, 10, -1, 0);
        send_frame("coll63",  100, 63, -1, 0);
        send_frame("coll70",  100, 70, -1, 0);
        send_frame("crclast", 200, -1, 199, 0);
        send_frame("crcpass", 200, -1, 5, 1);
        send_frame("goodpass",300, -1, -1, 1);
    endtask

    task automatic t_clear_on_sof();
        send_frame("pre", 80, -1, 3, 0);
        @(negedge clk);
        rx_valid = 1; rx_sof = 1;
        @(negedge clk);
        idle();
        chk("R6 clear count", int'(rpt_bcnt), 0);
        chk("R6 clear status", int'(rpt_status), 0);
        chk("R6 clear keep/drop", int'({rpt_keep, rpt_drop}), 0);
        drive_bytes(79, -1, -1, 1'b0);
        chk("R6 rest of frame count", int'(rpt_bcnt), 80);
        chk("R6 rest of frame kept", int'(rpt_keep), 1);
    endtask

    task automatic t_stray();
        send_frame("base", 90, -1, -1, 0);
        drive_bytes(30, -1, -1, 1'b0);
        drive_bytes(5, 2, 3, 1'b0);
        chk("R9 stray count", int'(rpt_bcnt), 90);
        chk("R9 stray status", int'(rpt_status), 0);
        send_frame("after", 70, -1, -1, 0);
    endtask

    task automatic t_host_read();
        send_frame("rd", 2003, -1, -1, 1);
        chk("R7 low byte", int'(rpt_bcnt[7:0]), 2003 % 256);
        @(negedge clk); host_rd_lo = 1;
        @(negedge clk); host_rd_lo = 0;
        chk("R7 hi captured", int'(rpt_bcnt_hi), 2003 / 256);
        send_frame("rd2", 300, -1, -1, 0);
        chk("R7 hi held", int'(rpt_bcnt_hi), 2003 / 256);
        @(negedge clk); host_rd_lo = 1;
        @(negedge clk); host_rd_lo = 0;
        chk("R7 hi recaptured", int'(rpt_bcnt_hi), 300 / 256);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_boundaries();
        t_faults();
        t_clear_on_sof();
        t_stray();
        t_host_read();
        finish_run();
    end
endmodule